// File: doc/BRIEF.md
# Programmable Periodic Interrupt Rate Divider

This block divides a 32768 Hz time-base enable down to a software-selected periodic rate. A divider counter advances on each time-base tick. At every full period it raises a sticky periodic flag, and at every half period it toggles a square-wave output. The rate comes from a 4-bit code. Code 0 switches periodic activity off. Codes 1 and 2 give 256 Hz and 128 Hz. Codes 3 to 15 divide the time base by 2^(n-1).

A 3-bit divider-control field either lets the counter run or holds it at zero. Two enable inputs gate what leaves the block. One turns the sticky flag into an interrupt request. The other lets the square wave reach its pin. The block sits under a register front end that supplies these fields, from bits 3:0 (rate) and 6:4 (divider control) of one control register and the enable bits of another. Software acknowledges the flag with a one-cycle clear strobe.

Top module: `periodic_rate_gen`

## Requirements
- R1: For rate code n in 3..15 on `rate_sel`, with the divider running and `tick` high every cycle from a fresh start, `per_flag` first rises after exactly 2^(n-1) ticks.
- R2: Rate code 1 gives a period of 128 ticks (256 Hz) and rate code 2 gives 256 ticks (128 Hz).
- R3: Rate code 0 produces no periodic flag and holds `sqw` low, however many ticks arrive.
- R4: The divider runs only while `div_ctl` equals 3'b010. Any other value holds the counter at zero with no events, and on return to 3'b010 a full period elapses before the next flag.
- R5: `per_flag` is set at each period boundary whatever `pie_en` is. It stays set until a `flag_clr` strobe, and a boundary in the same cycle as a strobe leaves it set.
- R6: `irq` is high exactly when `per_flag` is high and `pie_en` is high.
- R7: The square wave toggles every half period, so its first rise after a fresh start comes after 2^(k-1) ticks for a period of 2^k ticks. `sqw` stays low while `sqw_en` is low.
- R8: Any change of `rate_sel` restarts the divider from zero, and the internal square-wave state returns low.
- R9: While `rst_n` is low, `per_flag`, `irq` and `sqw` are low. Reset is applied asynchronously and released synchronously.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | One-cycle enable at the 32768 Hz time-base rate |
| rate_sel | input | 4 | Rate code (control register A bits 3:0) |
| div_ctl | input | 3 | Divider-control field (control register A bits 6:4) |
| pie_en | input | 1 | Periodic interrupt enable |
| sqw_en | input | 1 | Square-wave output enable |
| flag_clr | input | 1 | One-cycle strobe that clears the sticky flag |
| per_flag | output | 1 | Sticky periodic flag |
| irq | output | 1 | Periodic interrupt request |
| sqw | output | 1 | Square-wave output |

## Verification
Every nonzero rate code is run from a fresh start with a continuous tick. The tick count to the first flag separates the power-of-two codes from the two irregular low codes, and the count to the first square-wave rise shows that the half-period toggle follows the same decode. Part-way runs are then cut off in two ways, by a non-run divider-control value and by a switch of rate code. The flag arrives a full period late after either one only if the counter truly restarts, so a design that resumes mid-count is caught. Holding the clear strobe across a boundary, and toggling the two enables around a set flag, separate the sticky flag from its gated outputs.

// File: rtl/prg_pkg.sv
package prg_pkg;
  localparam int RATE_W = 4;
  localparam int DV_W   = 3;
  localparam int EXP_W  = 5;
  localparam int CNT_W  = (1 << RATE_W) - 2;
  localparam logic [DV_W-1:0] DV_RUN = 3'b010;
  localparam logic [EXP_W-1:0] EXP_CODE1 = 5'd7;
  localparam logic [EXP_W-1:0] EXP_CODE2 = 5'd8;
endpackage

// File: rtl/prg_rate_decode.sv
module prg_rate_decode
  import prg_pkg::*;
(
  input  logic [RATE_W-1:0] rate_i,
  output logic [CNT_W-1:0]  period_m1_o,
  output logic [CNT_W-1:0]  half_m1_o
);
  logic [EXP_W-1:0] exp_v;
  logic [CNT_W:0]   span;

  always_comb begin
    unique case (rate_i)
      RATE_W'(0): exp_v = '0;
      RATE_W'(1): exp_v = EXP_CODE1;
      RATE_W'(2): exp_v = EXP_CODE2;
      default:    exp_v = EXP_W'(rate_i) - EXP_W'(1);
    endcase
    span        = ({{CNT_W{1'b0}}, 1'b1} << exp_v) - 1'b1;
    period_m1_o = span[CNT_W-1:0];
    half_m1_o   = period_m1_o >> 1;
  end
endmodule

// File: rtl/prg_divider.sv
module prg_divider
  import prg_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic [RATE_W-1:0] rate_i,
  input  logic [CNT_W-1:0]  period_m1_i,
  input  logic [CNT_W-1:0]  half_m1_i,
  output logic              per_evt_o,
  output logic              half_evt_o,
  output logic              restart_o
);
  logic [RATE_W-1:0] rate_q;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              cnt_en, wrap, active;

  always_comb begin
    restart_o  = (rate_i != rate_q);
    active     = run_i & ~restart_o & tick_i;
    wrap       = (cnt_q == period_m1_i);
    per_evt_o  = active & wrap;
    half_evt_o = active & ((cnt_q & half_m1_i) == half_m1_i);
    cnt_en     = restart_o | ~run_i | tick_i;
    if (restart_o || !run_i) cnt_d = '0;
    else if (wrap)           cnt_d = '0;
    else                     cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rate_q <= '0;
      cnt_q  <= '0;
    end else begin
      rate_q <= rate_i;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  a_r8_restart_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i != rate_q) |=> (cnt_q == '0));
  a_r4_hold_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (cnt_q == '0));
  a_r1_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && rate_i == rate_q) |-> (cnt_q <= period_m1_i));
  a_r3_no_event_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rate_i == '0) |-> !per_evt_o);
endmodule

// File: rtl/prg_outputs.sv
module prg_outputs (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic per_evt_i,
  input  logic half_evt_i,
  input  logic restart_i,
  input  logic clr_i,
  input  logic pie_i,
  input  logic sqwe_i,
  input  logic rate_nz_i,
  output logic flag_o,
  output logic irq_o,
  output logic sqw_o
);
  logic flag_q, flag_d, sq_q, sq_d, sq_en;

  always_comb begin
    flag_d = per_evt_i | (flag_q & ~clr_i);
    sq_en  = restart_i | half_evt_i;
    sq_d   = restart_i ? 1'b0 : ~sq_q;
    flag_o = flag_q;
    irq_o  = flag_q & pie_i;
    sqw_o  = sq_q & sqwe_i & rate_nz_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      flag_q <= 1'b0;
      sq_q   <= 1'b0;
    end else begin
      flag_q <= flag_d;
      if (sq_en) sq_q <= sq_d;
    end
  end

  a_r5_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_q && !clr_i) |=> flag_q);
  a_r5_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
    per_evt_i |=> flag_q);
  a_r7_sq_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_evt_i && !restart_i) |=> $stable(sq_q));
  a_r8_sq_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> !sq_q);
endmodule

// File: rtl/periodic_rate_gen.sv
module periodic_rate_gen
  import prg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [RATE_W-1:0] rate_sel,
  input  logic [DV_W-1:0]   div_ctl,
  input  logic              pie_en,
  input  logic              sqw_en,
  input  logic              flag_clr,
  output logic              per_flag,
  output logic              irq,
  output logic              sqw
);
  logic [1:0]       rst_sync;
  logic             rst_int_n, run, rate_nz;
  logic [CNT_W-1:0] period_m1, half_m1;
  logic             per_evt, half_evt, restart;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int_n = rst_sync[1];

  assign rate_nz = (rate_sel != '0);
  assign run     = (div_ctl == DV_RUN) & rate_nz;

  prg_rate_decode u_dec (
    .rate_i(rate_sel), .period_m1_o(period_m1), .half_m1_o(half_m1)
  );

  prg_divider u_div (
    .clk_i(clk), .rst_ni(rst_int_n), .tick_i(tick), .run_i(run),
    .rate_i(rate_sel), .period_m1_i(period_m1), .half_m1_i(half_m1),
    .per_evt_o(per_evt), .half_evt_o(half_evt), .restart_o(restart)
  );

  prg_outputs u_out (
    .clk_i(clk), .rst_ni(rst_int_n), .per_evt_i(per_evt),
    .half_evt_i(half_evt), .restart_i(restart), .clr_i(flag_clr),
    .pie_i(pie_en), .sqwe_i(sqw_en), .rate_nz_i(rate_nz),
    .flag_o(per_flag), .irq_o(irq), .sqw_o(sqw)
  );

  a_r4_no_event_stopped: assert property (@(posedge clk) disable iff (!rst_int_n)
    (div_ctl != DV_RUN) |-> !per_evt);
  a_r6_irq_gate: assert property (@(posedge clk) disable iff (!rst_int_n)
    !pie_en |-> !irq);
  a_r7_sqw_gate: assert property (@(posedge clk) disable iff (!rst_int_n)
    !sqw_en |-> !sqw);
endmodule

// File: tb/periodic_rate_gen_test.sv
module periodic_rate_gen_test;
  localparam int CLK_PERIOD = 10;
  localparam int LIMIT = 40000;

  logic clk, rst_n, tick, pie_en, sqw_en, flag_clr;
  logic [3:0] rate_sel;
  logic [2:0] div_ctl;
  logic per_flag, irq, sqw;
  int checks, failures;
  bit done;

  periodic_rate_gen uut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .rate_sel(rate_sel),
    .div_ctl(div_ctl), .pie_en(pie_en), .sqw_en(sqw_en),
    .flag_clr(flag_clr), .per_flag(per_flag), .irq(irq), .sqw(sqw)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // fresh start on code, returns ticks to first flag and first sqw rise
  task automatic run_code(input logic [3:0] code, output int n_flag, output int n_sq);
    tick = 0; rate_sel = 4'd0; flag_clr = 1; div_ctl = 3'b010;
    @(negedge clk);
    rate_sel = code; flag_clr = 0;
    @(negedge clk);
    @(negedge clk);
    tick = 1; n_flag = 0; n_sq = 0;
    for (int i = 1; i <= LIMIT; i++) begin
      @(negedge clk);
      if (sqw && n_sq == 0) n_sq = i;
      if (per_flag) begin n_flag = i; break; end
    end
    tick = 0;
  endtask

  task automatic t_reset;
    rst_n = 0; tick = 0; rate_sel = 4'd3; div_ctl = 3'b010;
    pie_en = 1; sqw_en = 1; flag_clr = 0;
    repeat (3) @(negedge clk);
    check("R9 reset per_flag", per_flag, 0);
    check("R9 reset irq", irq, 0);
    check("R9 reset sqw", sqw, 0);
    rst_n = 1;
    repeat (3) @(negedge clk);
    pie_en = 0;
  endtask

  task automatic t_pow2;
    int nf, ns;
    for (int c = 3; c <= 15; c++) begin
      run_code(4'(c), nf, ns);
      check($sformatf("R1 period code %0d", c), nf, 1 << (c - 1));
      check($sformatf("R7 half period code %0d", c), ns, 1 << (c - 2));
    end
  endtask

  task automatic t_low_codes;
    int nf, ns;
    run_code(4'd1, nf, ns);
    check("R2 code 1 period", nf, 128);
    check("R7 code 1 half", ns, 64);
    run_code(4'd2, nf, ns);
    check("R2 code 2 period", nf, 256);
    check("R7 code 2 half", ns, 128);
  endtask

  task automatic t_code_zero;
    int seen_f, seen_s;
    flag_clr = 1; rate_sel = 4'd0; @(negedge clk); flag_clr = 0;
    tick = 1; seen_f = 0; seen_s = 0;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (per_flag) seen_f = 1;
      if (sqw) seen_s = 1;
    end
    tick = 0;
    check("R3 no flag at code 0", seen_f, 0);
    check("R3 sqw low at code 0", seen_s, 0);
  endtask

  task automatic t_div_stop;
    int n, seen;
    flag_clr = 1; rate_sel = 4'd0; @(negedge clk);
    flag_clr = 0; rate_sel = 4'd4; @(negedge clk); @(negedge clk);
    tick = 1; repeat (5) @(negedge clk);
    div_ctl = 3'b000; seen = 0;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (per_flag) seen = 1; end
    check("R4 no flag while stopped", seen, 0);
    div_ctl = 3'b110;
    for (int i = 0; i < 20; i++) begin @(negedge clk); if (per_flag) seen = 1; end
    check("R4 no flag for other code", seen, 0);
    div_ctl = 3'b010; n = 0;
    for (int i = 1; i <= 40; i++) begin @(negedge clk); if (per_flag) begin n = i; break; end end
    tick = 0;
    check("R4 full period after resume", n, 8);
  endtask

  task automatic t_rate_change;
    int n;
    flag_clr = 1; rate_sel = 4'd0; @(negedge clk);
    flag_clr = 0; rate_sel = 4'd4; @(negedge clk); @(negedge clk);
    tick = 1; repeat (5) @(negedge clk);
    rate_sel = 4'd3; n = 0;
    for (int i = 1; i <= 40; i++) begin @(negedge clk); if (per_flag) begin n = i; break; end end
    tick = 0;
    check("R8 restart edge plus 4 ticks", n, 5);
    check("R8 sqw low at flag", sqw, 0);
  endtask

  task automatic t_flag_irq;
    int nf, ns;
    run_code(4'd3, nf, ns);
    check("R5 set with pie_en low", per_flag, 1);
    check("R6 irq low with pie_en low", irq, 0);
    repeat (10) @(negedge clk);
    check("R5 stays set", per_flag, 1);
    pie_en = 1; #1;
    check("R6 irq follows flag", irq, 1);
    @(negedge clk); flag_clr = 1; @(negedge clk); flag_clr = 0;
    check("R5 cleared by strobe", per_flag, 0);
    check("R6 irq low after clear", irq, 0);
    // clear held across the boundary: set must win
    rate_sel = 4'd0; @(negedge clk);
    rate_sel = 4'd3; @(negedge clk); @(negedge clk);
    flag_clr = 1; tick = 1;
    repeat (4) @(negedge clk);
    check("R5 set wins over clear", per_flag, 1);
    tick = 0; @(negedge clk);
    check("R5 clear after boundary", per_flag, 0);
    flag_clr = 0; pie_en = 0;
  endtask

  task automatic t_sqw_gate;
    int seen;
    sqw_en = 0; rate_sel = 4'd0; @(negedge clk);
    rate_sel = 4'd3; @(negedge clk); @(negedge clk);
    tick = 1; seen = 0;
    for (int i = 0; i < 16; i++) begin @(negedge clk); if (sqw) seen = 1; end
    tick = 0;
    check("R7 sqw low while disabled", seen, 0);
    sqw_en = 1;
  endtask

  initial begin
    checks = 0; failures = 0; done = 0;
    t_reset();
    t_pow2();
    t_low_codes();
    t_code_zero();
    t_div_stop();
    t_rate_change();
    t_flag_irq();
    t_sqw_gate();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule